// File: doc/BRIEF.md
# Two-Phase Shared-Pin Cache Port

This block lets a split instruction cache and data cache share one external address bus and one data bus. Every processor cycle is split into two half-cycle slots, and the block runs on a clock at the half-cycle rate. In the first slot it drives the pending data address toward the data cache, while the instruction word requested in the slot before arrives on the read bus. In the second slot it drives the next fetch address toward the instruction cache, while the data access finishes. For a store, the data access finishes by driving the write bus with a write strobe. For a load, it finishes by capturing the returned word.

The caches are modelled as synchronous SRAMs. Each one registers the address and select on one clock edge, returns read data during the following half-cycle, and completes a write at the end of that half-cycle to the address it registered. The core presents a data request once per processor cycle. The fetch address is sampled once per processor cycle, on the other edge. In return the core gets one instruction word and at most one loaded data word each cycle.

Top module: `split_cache_port`

## Requirements
- R1: `phase_o` is 0 (data-address slot) in the first half-cycle after reset and inverts on every rising edge of `clk_i`; 1 marks the instruction-address slot.
- R2: While `phase_o` is 0, `bus_addr_o` carries the address of the data request held for this cycle and `bus_dsel_o` is 1; with no request held, `bus_addr_o` is 0 and `bus_dsel_o` is 0.
- R3: While `phase_o` is 1, `bus_addr_o` equals `fetch_addr_i` as sampled on the edge that ended the preceding phase-0 slot, and `bus_isel_o` is 1; `bus_isel_o` is 0 in phase 0.
- R4: `bus_we_o` and `bus_oe_o` are 1 only during phase 1 of a cycle that holds a write request, and `bus_wdata_o` then carries its write data; otherwise `bus_wdata_o` is 0.
- R5: Starting with the first phase-0 slot that follows a phase-1 slot, every edge that ends a phase-0 slot loads `instr_o` from `bus_rdata_i` and sets `instr_valid_o` to 1. Before that, both stay 0.
- R6: For a held read request, the edge that ends phase 1 loads `drd_o` from `bus_rdata_i` and sets `drd_valid_o`, which stays 1 until the next edge that ends a phase-1 slot.
- R7: For a cycle with a write request or with no request, the edge that ends phase 1 leaves `drd_o` unchanged and clears `drd_valid_o`.
- R8: The data-request inputs are sampled only on the edge that ends a phase-1 slot. Changes to them at any other time have no effect on the bus or on captured data.
- R9: While `rst_ni` is low, every output is 0.
- R10: `bus_isel_o` and `bus_dsel_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Half-cycle clock; two rising edges per processor cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_addr_i | input | AW | Next instruction fetch address |
| dreq_valid_i | input | 1 | Data request present |
| dreq_we_i | input | 1 | Data request is a write |
| dreq_addr_i | input | AW | Data request address |
| dreq_wdata_i | input | DW | Data request write data |
| bus_rdata_i | input | DW | Shared read data bus from both caches |
| phase_o | output | 1 | Current slot: 0 data address, 1 instruction address |
| bus_addr_o | output | AW | Shared address bus |
| bus_isel_o | output | 1 | Address slot belongs to the instruction cache |
| bus_dsel_o | output | 1 | Address slot belongs to the data cache |
| bus_we_o | output | 1 | Data cache write strobe |
| bus_oe_o | output | 1 | Write bus is driven |
| bus_wdata_o | output | DW | Shared write data bus |
| instr_o | output | DW | Captured instruction word |
| instr_valid_o | output | 1 | Instruction word is valid |
| drd_o | output | DW | Captured load word |
| drd_valid_o | output | 1 | Load word captured in the last cycle |

## Verification
Some properties are checked by assertions on every cycle. The slot alternates strictly. The two selects never coincide. The write strobe appears only in the instruction-address slot and only for a held write. The captured request, the fetch address and both captured words stay frozen during the half-cycle in which they must not move. Whether the words delivered are the right ones cannot be seen that way. That covers the instruction word matching the address fetched two edges earlier, a load returning the value stored by an earlier write, and request changes between sampling edges being ignored. The bench shows these by running a shared memory model against a behavioural reference through idle, store, load-back and randomly changing request streams.

// File: rtl/spc_pkg.sv
package spc_pkg;
  typedef enum logic {
    PH_DADDR = 1'b0,  // data address out, instruction word in
    PH_IADDR = 1'b1   // instruction address out, data op completes
  } phase_e;
endpackage

// File: rtl/spc_phase.sv
module spc_phase
  import spc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  output phase_e ph_o,
  output logic   started_o
);
  phase_e ph_q;
  logic   started_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q      <= PH_DADDR;
      started_q <= 1'b0;
    end else begin
      ph_q <= (ph_q == PH_DADDR) ? PH_IADDR : PH_DADDR;
      if (ph_q == PH_IADDR) started_q <= 1'b1;
    end
  end

  assign ph_o      = ph_q;
  assign started_o = started_q;

  a_r1_phase_toggle_d: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_DADDR) |=> (ph_q == PH_IADDR));
  a_r1_phase_toggle_i: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_IADDR) |=> (ph_q == PH_DADDR));
  a_r5_started_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |=> started_q);
endmodule

// File: rtl/spc_req_slot.sv
module spc_req_slot
  import spc_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  phase_e        ph_i,
  input  logic [AW-1:0] fetch_addr_i,
  input  logic          dreq_valid_i,
  input  logic          dreq_we_i,
  input  logic [AW-1:0] dreq_addr_i,
  input  logic [DW-1:0] dreq_wdata_i,
  output logic          slot_v_o,
  output logic          slot_we_o,
  output logic [AW-1:0] slot_addr_o,
  output logic [DW-1:0] slot_wdata_o,
  output logic [AW-1:0] iaddr_o
);
  logic          v_q, we_q;
  logic [AW-1:0] a_q, ia_q;
  logic [DW-1:0] wd_q;

  // request taken at cycle start, fetch address at the mid-cycle edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q  <= 1'b0;
      we_q <= 1'b0;
      a_q  <= '0;
      wd_q <= '0;
      ia_q <= '0;
    end else if (ph_i == PH_IADDR) begin
      v_q  <= dreq_valid_i;
      we_q <= dreq_valid_i & dreq_we_i;
      a_q  <= dreq_valid_i ? dreq_addr_i : '0;
      wd_q <= (dreq_valid_i & dreq_we_i) ? dreq_wdata_i : '0;
    end else begin
      ia_q <= fetch_addr_i;
    end
  end

  assign slot_v_o     = v_q;
  assign slot_we_o    = we_q;
  assign slot_addr_o  = a_q;
  assign slot_wdata_o = wd_q;
  assign iaddr_o      = ia_q;

  a_r8_slot_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_i == PH_IADDR) |-> $stable({v_q, we_q, a_q, wd_q}));
  a_r3_iaddr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_i == PH_DADDR) |-> $stable(ia_q));
endmodule

// File: rtl/spc_bus_drive.sv
module spc_bus_drive
  import spc_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  phase_e        ph_i,
  input  logic          slot_v_i,
  input  logic          slot_we_i,
  input  logic [AW-1:0] slot_addr_i,
  input  logic [DW-1:0] slot_wdata_i,
  input  logic [AW-1:0] iaddr_i,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_isel_o,
  output logic          bus_dsel_o,
  output logic          bus_we_o,
  output logic          bus_oe_o,
  output logic [DW-1:0] bus_wdata_o
);
  logic wr_slot;

  assign wr_slot = slot_v_i & slot_we_i;

  always_comb begin
    bus_addr_o  = '0;
    bus_isel_o  = 1'b0;
    bus_dsel_o  = 1'b0;
    bus_we_o    = 1'b0;
    bus_oe_o    = 1'b0;
    bus_wdata_o = '0;
    if (!rst_ni) begin
      bus_addr_o = '0;
    end else if (ph_i == PH_DADDR) begin
      bus_dsel_o = slot_v_i;
      if (slot_v_i) bus_addr_o = slot_addr_i;
    end else begin
      bus_isel_o = 1'b1;
      bus_addr_o = iaddr_i;
      if (wr_slot) begin
        bus_we_o    = 1'b1;
        bus_oe_o    = 1'b1;
        bus_wdata_o = slot_wdata_i;
      end
    end
  end

  a_r10_sel_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_isel_o && bus_dsel_o));
  a_r4_we_in_iaddr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_o |-> (ph_i == PH_IADDR) && slot_v_i && slot_we_i);
  a_r4_oe_with_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o == bus_we_o);
endmodule

// File: rtl/spc_capture.sv
module spc_capture
  import spc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  phase_e        ph_i,
  input  logic          started_i,
  input  logic          slot_v_i,
  input  logic          slot_we_i,
  input  logic [DW-1:0] rdata_i,
  output logic [DW-1:0] instr_o,
  output logic          instr_v_o,
  output logic [DW-1:0] drd_o,
  output logic          drd_v_o
);
  logic          rd_slot;
  logic [DW-1:0] instr_q, drd_q;
  logic          instr_v_q, drd_v_q;

  assign rd_slot = slot_v_i & ~slot_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      instr_q   <= '0;
      instr_v_q <= 1'b0;
      drd_q     <= '0;
      drd_v_q   <= 1'b0;
    end else if (ph_i == PH_DADDR) begin
      if (started_i) begin
        instr_q   <= rdata_i;
        instr_v_q <= 1'b1;
      end
    end else begin
      drd_v_q <= rd_slot;
      if (rd_slot) drd_q <= rdata_i;
    end
  end

  assign instr_o   = instr_q;
  assign instr_v_o = instr_v_q;
  assign drd_o     = drd_q;
  assign drd_v_o   = drd_v_q;

  a_r5_instr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_i == PH_DADDR) |-> $stable({instr_q, instr_v_q}));
  a_r6_drd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_i == PH_IADDR) |-> $stable({drd_q, drd_v_q}));
endmodule

// File: rtl/split_cache_port.sv
module split_cache_port
  import spc_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] fetch_addr_i,
  input  logic          dreq_valid_i,
  input  logic          dreq_we_i,
  input  logic [AW-1:0] dreq_addr_i,
  input  logic [DW-1:0] dreq_wdata_i,
  input  logic [DW-1:0] bus_rdata_i,
  output logic          phase_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_isel_o,
  output logic          bus_dsel_o,
  output logic          bus_we_o,
  output logic          bus_oe_o,
  output logic [DW-1:0] bus_wdata_o,
  output logic [DW-1:0] instr_o,
  output logic          instr_valid_o,
  output logic [DW-1:0] drd_o,
  output logic          drd_valid_o
);
  phase_e        ph;
  logic          started;
  logic          slot_v, slot_we;
  logic [AW-1:0] slot_addr, iaddr;
  logic [DW-1:0] slot_wdata;

  spc_phase u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ph_o      (ph),
    .started_o (started)
  );

  spc_req_slot #(.AW(AW), .DW(DW)) u_slot (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ph_i         (ph),
    .fetch_addr_i (fetch_addr_i),
    .dreq_valid_i (dreq_valid_i),
    .dreq_we_i    (dreq_we_i),
    .dreq_addr_i  (dreq_addr_i),
    .dreq_wdata_i (dreq_wdata_i),
    .slot_v_o     (slot_v),
    .slot_we_o    (slot_we),
    .slot_addr_o  (slot_addr),
    .slot_wdata_o (slot_wdata),
    .iaddr_o      (iaddr)
  );

  spc_bus_drive #(.AW(AW), .DW(DW)) u_drive (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ph_i         (ph),
    .slot_v_i     (slot_v),
    .slot_we_i    (slot_we),
    .slot_addr_i  (slot_addr),
    .slot_wdata_i (slot_wdata),
    .iaddr_i      (iaddr),
    .bus_addr_o   (bus_addr_o),
    .bus_isel_o   (bus_isel_o),
    .bus_dsel_o   (bus_dsel_o),
    .bus_we_o     (bus_we_o),
    .bus_oe_o     (bus_oe_o),
    .bus_wdata_o  (bus_wdata_o)
  );

  spc_capture #(.DW(DW)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ph_i      (ph),
    .started_i (started),
    .slot_v_i  (slot_v),
    .slot_we_i (slot_we),
    .rdata_i   (bus_rdata_i),
    .instr_o   (instr_o),
    .instr_v_o (instr_valid_o),
    .drd_o     (drd_o),
    .drd_v_o   (drd_valid_o)
  );

  assign phase_o = ph;
endmodule

// File: tb/split_cache_port_test.sv
module split_cache_port_test;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] fa = '0;
  logic          dv = 1'b0, dwe = 1'b0;
  logic [AW-1:0] da = '0;
  logic [DW-1:0] dwd = '0;
  logic [DW-1:0] rdata;

  logic          phase, isel, dsel, we, oe, iv, rv;
  logic [AW-1:0] baddr;
  logic [DW-1:0] wdata, instr, rword;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  split_cache_port #(.AW(AW), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .fetch_addr_i(fa),
    .dreq_valid_i(dv), .dreq_we_i(dwe), .dreq_addr_i(da), .dreq_wdata_i(dwd),
    .bus_rdata_i(rdata), .phase_o(phase), .bus_addr_o(baddr),
    .bus_isel_o(isel), .bus_dsel_o(dsel), .bus_we_o(we), .bus_oe_o(oe),
    .bus_wdata_o(wdata), .instr_o(instr), .instr_valid_o(iv),
    .drd_o(rword), .drd_valid_o(rv)
  );

  function automatic logic [DW-1:0] imem_word(logic [AW-1:0] a);
    return {8'hA5, 8'h3C, a};
  endfunction

  // shared synchronous SRAM model (both caches behind one pin set)
  logic [DW-1:0] dmem [256];
  logic [AW-1:0] m_a = '0;
  logic          m_is = 1'b0, m_ds = 1'b0;
  logic [AW-1:0] s_addr = '0;
  logic          s_is = 1'b0, s_ds = 1'b0, s_we = 1'b0;
  logic [DW-1:0] s_wd = '0;

  assign rdata = m_is ? imem_word(m_a) : (m_ds ? dmem[m_a[7:0]] : '0);

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) dmem[i] <= 32'h1000_0000 + i;
    end else if (s_we && m_ds) begin
      dmem[m_a[7:0]] <= s_wd;
    end
    m_a  <= s_addr;
    m_is <= s_is;
    m_ds <= s_ds;
  end

  // behavioural reference
  logic [DW-1:0] ref_dmem [256];
  bit            ph_m, started_m, iv_m, rv_m;
  bit            sv_m, swe_m;
  logic [AW-1:0] sa_m, ia_m, ipend_m;
  logic [DW-1:0] swd_m, instr_m, rword_m;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) ref_dmem[i] = 32'h1000_0000 + i;
      ph_m = 0; started_m = 0; iv_m = 0; rv_m = 0;
      sv_m = 0; swe_m = 0; sa_m = '0; ia_m = '0; ipend_m = '0;
      swd_m = '0; instr_m = '0; rword_m = '0;
    end else if (!ph_m) begin
      if (started_m) begin
        instr_m = imem_word(ipend_m);
        iv_m = 1;
      end
      ia_m = fa;
      ph_m = 1;
    end else begin
      rv_m = sv_m && !swe_m;
      if (sv_m && !swe_m) rword_m = ref_dmem[sa_m[7:0]];
      if (sv_m && swe_m) ref_dmem[sa_m[7:0]] = swd_m;
      ipend_m = ia_m;
      started_m = 1;
      sv_m = dv; swe_m = dv && dwe;
      sa_m = dv ? da : '0;
      swd_m = (dv && dwe) ? dwd : '0;
      ph_m = 0;
    end
  end

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [AW-1:0] ea;
    chk("R1 phase", DW'(phase), DW'(ph_m));
    chk("R10 sel exclusive", DW'(isel & dsel), '0);
    if (!ph_m) begin
      ea = sv_m ? sa_m : '0;
      chk("R2 data address", DW'(baddr), DW'(ea));
      chk("R2 dsel", DW'(dsel), DW'(sv_m));
      chk("R3 isel low", DW'(isel), '0);
      chk("R4 we low", DW'({we, oe}), '0);
      chk("R4 wdata idle", wdata, '0);
    end else begin
      chk("R3 fetch address", DW'(baddr), DW'(ia_m));
      chk("R3 isel", DW'(isel), 32'd1);
      chk("R2 dsel low", DW'(dsel), '0);
      chk("R4 R8 we/oe", DW'({we, oe}), (sv_m && swe_m) ? 32'd3 : 32'd0);
      chk("R4 R8 wdata", wdata, (sv_m && swe_m) ? swd_m : '0);
    end
    chk("R5 instr", instr, instr_m);
    chk("R5 instr valid", DW'(iv), DW'(iv_m));
    chk("R6 R7 load word", rword, rword_m);
    chk("R7 R6 load valid", DW'(rv), DW'(rv_m));
  endtask

  task automatic half(logic [AW-1:0] f, bit v, bit w, logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    check_all();
    s_addr = baddr; s_is = isel; s_ds = dsel; s_we = we; s_wd = wdata;
    fa = f; dv = v; dwe = w; da = a; dwd = d;
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R9 reset state
    chk("R9 reset ctrl", DW'({phase, isel, dsel, we, oe, iv, rv}), '0);
    chk("R9 reset addr", DW'(baddr), '0);
    chk("R9 reset wdata", wdata, '0);
    chk("R9 reset instr", instr, '0);
    chk("R9 reset load", rword, '0);
    rst_n = 1'b1;
    // idle: fetch continues, no data traffic (R2, R5, R7)
    for (int h = 0; h < 16; h++) half(AW'(h * 4), 0, 0, '0, '0);
    // stores, inputs held for whole cycles
    for (int i = 0; i < 12; i++) begin
      half(AW'(100 + i), 1, 1, AW'(i * 3), 32'hBEEF_0000 + i);
      half(AW'(100 + i), 1, 1, AW'(i * 3), 32'hBEEF_0000 + i);
    end
    // loads back the stored words (R6)
    for (int i = 0; i < 12; i++) begin
      half(AW'(140 + i), 1, 0, AW'(i * 3), '0);
      half(AW'(140 + i), 1, 0, AW'(i * 3), '0);
    end
    // back-to-back store then load of one address
    half(16'd7, 1, 1, 16'd200, 32'hCAFE_F00D);
    half(16'd7, 1, 1, 16'd200, 32'hCAFE_F00D);
    half(16'd8, 1, 0, 16'd200, '0);
    half(16'd8, 1, 0, 16'd200, '0);
    // request inputs change every half-cycle (R8)
    for (int h = 0; h < 400; h++)
      half(AW'($urandom_range(0, 255)), bit'($urandom_range(0, 1)),
           bit'($urandom_range(0, 1)), AW'($urandom_range(0, 31)), $urandom);
    for (int h = 0; h < 8; h++) half('0, 0, 0, '0, '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule